// File: doc/BRIEF.md
# Dual-Channel Serial Word Checker with Response Bus Tracking

This block watches two redundant serial bus channels. Each channel arrives as a pair of complementary lines that are sampled at sixteen samples per bit cell. It decodes every word that appears on either channel. A word has a three-bit-time sync pattern, sixteen data bits in biphase (Manchester II) code and one parity bit. Each finished word is reported once with its data, its sync type, the channel it came from and a validity flag.

A word is valid only if all of these hold: the sync has the right shape, every bit cell has its mid-cell transition, and parity over the data and parity bits is odd. A word that carries a data sync must also follow a valid word on the same channel with at most a short idle gap. Without this rule, a data word that has lost its message would be accepted.

The block also selects the bus the transmitter should answer on. In terminal mode it keeps the channel of the last valid command-sync word. In controller mode the host chooses the bus through a select input.

Top module: `bus_word_validator`

## Requirements
- R1: A command sync is 24 samples high followed by 24 samples low. A data sync is 24 samples low followed by 24 samples high. The output word_is_cmd is 1 for a command sync and 0 for a data sync. Any sync that does not hold one level for the first 24 samples and the opposite level for the next 24 samples makes the word invalid.
- R2: After the sync come 16 data bits, most significant bit first, then one parity bit. Each bit cell is 16 samples long. A 1 is high in the first 8 samples and low in the last 8, and a 0 is the reverse. word_data carries the 16 data bits.
- R3: A bit cell whose two halves have the same level makes the word invalid. A cell where the line goes idle (both lines equal) has the same effect.
- R4: The 16 data bits plus the parity bit must contain an odd number of ones. Otherwise the word is invalid.
- R5: A data-sync word is valid only under two conditions. The previous word on the same channel was valid, and the new word begins fewer than 32 idle samples (2 bit times) after that word ended. A command-sync word is not subject to this rule.
- R6: word_strobe is high for exactly one cycle. It rises in the cycle after the clock edge that takes the 320th sample of a word. word_data, word_is_cmd, word_bus and word_valid hold their values until the next strobe.
- R7: word_bus gives the channel index (0 or 1) on which the word arrived.
- R8: When ctrl_mode is 0, resp_bus equals the channel of the most recent valid command-sync word. Invalid words and data words leave it unchanged. It is 0 after reset.
- R9: When ctrl_mode is 1, resp_bus equals host_bus_sel. Valid command words received meanwhile are still tracked, and their channel appears on resp_bus once ctrl_mode returns to 0.
- R10: During and just after reset, word_strobe and word_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 samples per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| line_hi | input | 2 | True line of each channel |
| line_lo | input | 2 | Complement line of each channel |
| ctrl_mode | input | 1 | 1 = host picks the response bus |
| host_bus_sel | input | 1 | Response bus used in controller mode |
| word_data | output | 16 | Decoded data bits |
| word_is_cmd | output | 1 | 1 = command sync, 0 = data sync |
| word_bus | output | 1 | Channel the word arrived on |
| word_valid | output | 1 | All checks passed |
| word_strobe | output | 1 | One-cycle pulse per finished word |
| resp_bus | output | 1 | Bus selected for the response |

## Verification
The strobe for a word is due exactly one cycle after the edge that takes the word's last sample. The bench drivers record that cycle as the due time, together with the expected fields, when they push an item into the queue. The monitor samples on falling edges, pops an item on each strobe and compares the arrival cycle as well as the fields. resp_bus changes on the same edge as the strobe of a valid command word, and it follows host_bus_sel within the same cycle in controller mode. For this reason the bench reads it only a few idle samples after the strobe has passed.

// File: rtl/bus_word_validator.sv
module bus_word_validator #(
  parameter int SPB      = 16,
  parameter int DBITS    = 16,
  parameter int GAP_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_hi,
  input  logic [1:0]       line_lo,
  input  logic             ctrl_mode,
  input  logic             host_bus_sel,
  output logic [DBITS-1:0] word_data,
  output logic             word_is_cmd,
  output logic             word_bus,
  output logic             word_valid,
  output logic             word_strobe,
  output logic             resp_bus
);
  localparam int SYNC_LEN  = 3 * SPB;
  localparam int SYNC_HALF = SYNC_LEN / 2;
  localparam int WORD_LEN  = SYNC_LEN + (DBITS + 1) * SPB;
  localparam int GAP_LIMIT = GAP_BITS * SPB;
  localparam int CW        = $clog2(WORD_LEN);
  localparam int GW        = $clog2(GAP_LIMIT + 1);

  localparam logic [CW-1:0] SYNC_LEN_C  = CW'(SYNC_LEN);
  localparam logic [CW-1:0] SYNC_HALF_C = CW'(SYNC_HALF);
  localparam logic [CW-1:0] LAST_C      = CW'(WORD_LEN - 1);
  localparam logic [CW-1:0] SPB_C       = CW'(SPB);
  localparam logic [CW-1:0] PT1_C       = CW'(SPB / 4);
  localparam logic [CW-1:0] PT2_C       = CW'(SPB / 2 + SPB / 4);
  localparam logic [GW-1:0] GAP_C       = GW'(GAP_LIMIT);

  logic [1:0]       done_v, ok_v, first_v, run_v;
  logic [DBITS-1:0] data_a [2];
  logic             last_cmd_bus;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic             act, lvl;
    logic             run, first, err, contig, mopen, half1, bad;
    logic [CW-1:0]    cnt, rel, pos;
    logic [GW-1:0]    gap;
    logic [DBITS:0]   sh;

    assign act = line_hi[c] ^ line_lo[c];
    assign lvl = line_hi[c];
    assign rel = cnt - SYNC_LEN_C;
    assign pos = rel % SPB_C;

    always_comb begin
      bad = !act;
      if (cnt < SYNC_HALF_C)     bad = bad | (lvl != first);
      else if (cnt < SYNC_LEN_C) bad = bad | (lvl == first);
      else if (pos == PT2_C)     bad = bad | (lvl == half1);
    end

    assign done_v[c]  = run && (cnt == LAST_C);
    assign ok_v[c]    = !err && !bad && (^sh) && (first || contig);
    assign first_v[c] = first;
    assign run_v[c]   = run;
    assign data_a[c]  = sh[DBITS:1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run <= 1'b0; cnt <= '0; first <= 1'b0; err <= 1'b0;
        contig <= 1'b0; mopen <= 1'b0; half1 <= 1'b0;
        gap <= GAP_C; sh <= '0;
      end else if (!run) begin
        if (act) begin
          run    <= 1'b1;
          cnt    <= CW'(1);
          first  <= lvl;
          err    <= 1'b0;
          contig <= mopen && (gap < GAP_C);
        end else if (gap < GAP_C) begin
          gap <= gap + GW'(1);
        end
      end else begin
        cnt <= cnt + CW'(1);
        if (bad) err <= 1'b1;
        if (cnt >= SYNC_LEN_C && pos == PT1_C) begin
          half1 <= lvl;
          sh    <= {sh[DBITS-1:0], lvl};
        end
        if (done_v[c]) begin
          run   <= 1'b0;
          gap   <= '0;
          mopen <= ok_v[c];
        end
      end
    end
  end

  logic sel;
  assign sel = !done_v[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_data <= '0; word_is_cmd <= 1'b0; word_bus <= 1'b0;
      word_valid <= 1'b0; word_strobe <= 1'b0; last_cmd_bus <= 1'b0;
    end else begin
      word_strobe <= |done_v;
      if (|done_v) begin
        word_data   <= data_a[sel];
        word_is_cmd <= first_v[sel];
        word_bus    <= sel;
        word_valid  <= ok_v[sel];
        if (ok_v[sel] && first_v[sel]) last_cmd_bus <= sel;
      end
    end
  end

  assign resp_bus = ctrl_mode ? host_bus_sel : last_cmd_bus;

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe);
  assert_strobe_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |-> $past(|run_v));
  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_mode && $past(!ctrl_mode) && !(word_strobe && word_valid && word_is_cmd))
      |-> $stable(resp_bus));
  assert_resp_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_mode && word_strobe && word_valid && word_is_cmd) |-> resp_bus == word_bus);
  assert_bad_word_no_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_strobe && !word_valid) |-> $stable(last_cmd_bus));
endmodule

// File: tb/sim_bus_word_validator.sv
module sim_bus_word_validator;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ctrl_mode, host_bus_sel;
  logic [1:0]  line_hi, line_lo;
  logic [15:0] word_data;
  logic        word_is_cmd, word_bus, word_valid, word_strobe, resp_bus;

  bus_word_validator u0 (.clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .ctrl_mode(ctrl_mode), .host_bus_sel(host_bus_sel), .word_data(word_data),
    .word_is_cmd(word_is_cmd), .word_bus(word_bus), .word_valid(word_valid),
    .word_strobe(word_strobe), .resp_bus(resp_bus));

  typedef struct {
    logic [15:0] d; logic cmd; logic bus; logic ok; int due; string tag;
  } exp_t;
  exp_t q[$];

  int  n_chk = 0, n_bad = 0, cyc = 0;
  int  idle_ct[2];
  bit  open_m[2];
  bit  prev_strobe = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit cond, string tag, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int ch, bit active, bit lv);
    @(negedge clk);
    line_hi = 2'b00; line_lo = 2'b00;
    if (active) begin line_hi[ch] = lv; line_lo[ch] = !lv; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
    idle_ct[0] += n; idle_ct[1] += n;
  endtask

  // fault: 0 none, 1 short sync, 2 no mid-cell transition in bit 5, 3 parity flip
  task automatic send(int ch, bit cmd, logic [15:0] d, int fault, string tag);
    exp_t e;
    bit par, v, lv;
    par = ~^d;
    if (fault == 3) par = ~par;
    for (int i = 0; i < 48; i++) begin
      lv = (i < ((fault == 1) ? 16 : 24)) ? cmd : !cmd;
      drive(ch, 1, lv);
    end
    for (int b = 0; b < 17; b++) begin
      v = (b < 16) ? d[15-b] : par;
      for (int s = 0; s < 16; s++) begin
        lv = (s < 8) ? v : !v;
        if (fault == 2 && b == 5) lv = v;
        drive(ch, 1, lv);
      end
    end
    e.d = d; e.cmd = cmd; e.bus = ch[0]; e.tag = tag; e.due = cyc + 1;
    e.ok = (fault == 0) && (cmd || (open_m[ch] && idle_ct[ch] < 32));
    open_m[ch] = e.ok;
    idle_ct[ch] = 0;
    idle_ct[1-ch] += 320;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_strobe && prev_strobe) chk(0, "R6 strobe longer than one cycle", 1, 0);
      if (word_strobe) begin
        if (q.size() == 0) chk(0, "R6 unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, {e.tag, " R6 timing"}, cyc, e.due);
          chk(word_valid == e.ok, {e.tag, " valid"}, word_valid, e.ok);
          chk(word_is_cmd == e.cmd, {e.tag, " R1 sync type"}, word_is_cmd, e.cmd);
          chk(word_bus == e.bus, {e.tag, " R7 bus"}, word_bus, e.bus);
          if (e.ok) chk(word_data == e.d, {e.tag, " R2 data"}, word_data, e.d);
        end
      end
      prev_strobe = word_strobe;
    end
  end

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ctrl_mode = 0; host_bus_sel = 0;
    line_hi = 2'b00; line_lo = 2'b00;
    idle_ct[0] = 100; idle_ct[1] = 100; open_m[0] = 0; open_m[1] = 0;
    repeat (5) @(negedge clk);
    chk(word_strobe == 0, "R10 strobe in reset", word_strobe, 0);
    rst_n = 1;
    @(negedge clk);
    chk(word_strobe == 0, "R10 strobe after reset", word_strobe, 0);
    chk(word_valid == 0, "R10 valid after reset", word_valid, 0);
    chk(resp_bus == 0, "R10 R8 resp after reset", resp_bus, 0);

    idle(40);
    send(0, 1, 16'hA5C3, 0, "R1 R2 R7 command");
    send(0, 0, 16'h0001, 0, "R1 R2 R5 back-to-back data");
    idle(20);
    send(0, 0, 16'hFFFE, 0, "R5 short gap data");
    idle(40);
    send(0, 0, 16'h1234, 0, "R5 long gap data");
    idle(3);
    chk(resp_bus == 0, "R8 resp after ch0 command", resp_bus, 0);

    idle(50);
    send(1, 1, 16'h8000, 0, "R7 R8 command ch1");
    idle(3);
    chk(resp_bus == 1, "R8 resp follows ch1 command", resp_bus, 1);
    idle(5);
    chk(word_data == 16'h8000, "R6 data held", word_data, 16'h8000);
    chk(word_bus == 1, "R6 bus held", word_bus, 1);

    send(1, 0, 16'h7FFF, 3, "R4 parity error");
    send(1, 0, 16'h0F0F, 0, "R5 data after bad word");
    idle(10);
    send(0, 0, 16'h3333, 0, "R5 R8 stray data ch0");
    idle(3);
    chk(resp_bus == 1, "R8 data word leaves resp", resp_bus, 1);
    send(1, 1, 16'h5555, 2, "R3 missing transition");
    send(0, 1, 16'h0F0F, 1, "R1 short sync");
    idle(3);
    chk(resp_bus == 1, "R8 invalid command leaves resp", resp_bus, 1);
    idle(5);
    send(0, 1, 16'hC001, 0, "R8 command ch0");
    idle(3);
    chk(resp_bus == 0, "R8 resp back to ch0", resp_bus, 0);

    ctrl_mode = 1; host_bus_sel = 1;
    idle(2);
    chk(resp_bus == 1, "R9 host select 1", resp_bus, 1);
    host_bus_sel = 0;
    idle(2);
    chk(resp_bus == 0, "R9 host select 0", resp_bus, 0);
    send(1, 1, 16'hBEEF, 0, "R9 command in controller mode");
    idle(3);
    chk(resp_bus == 0, "R9 host select wins", resp_bus, 0);
    ctrl_mode = 0;
    idle(2);
    chk(resp_bus == 1, "R9 tracked bus after mode exit", resp_bus, 1);

    idle(10);
    chk(q.size() == 0, "R6 missing strobes", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule